// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank-State Tracker

This block listens to the command pins of a double-data-rate SDRAM control interface from the memory side. On every rising clock edge it samples chip select, the three command strobes, clock enable, two bank bits and a 13-bit address. It turns them into one decoded command and keeps, for each of four banks, whether a row is open and which row it is. Commands that make no sense for the present bank state are flagged and have no effect.

Clock enable drives a small power-state machine. If clock enable drops with every bank idle, the block enters precharge power-down. If it drops while a row is open, the block enters active power-down. If it drops together with a refresh, the block enters self refresh. Dropping clock enable during a read or write burst raises an error flag. While a write burst is in progress, the two byte-mask inputs are expanded every cycle into a per-bit keep pattern for a 16-bit data path.

All outputs are registered. They show the effect of the inputs sampled at a rising edge right after that edge.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: With `cs_n` high while running, `cmd_o` reads 0 (deselect) and no bank state changes, whatever the strobes carry.
- R2: With `cs_n` low, `{ras_n,cas_n,we_n}` decode as 111 NOP, 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 REFRESH, 000 MODE SET, 110 BURST STOP, and `cmd_o` reports them as 1, 2, 3, 4, 5, 6, 7, 8.
- R3: ACTIVE opens bank `ba` with row `addr`, and `row_o` shows that row. READ/WRITE report the stored row of bank `ba` on `row_o`, report the column (addr with bit 10 removed) on `col_o`, and report address bit 10 on `ap_o`.
- R4: PRECHARGE with address bit 10 low closes only bank `ba`. With bit 10 high it closes all banks.
- R5: READ or WRITE to an idle bank, ACTIVE to an open bank, or REFRESH while any bank is open sets `illegal_o` for one cycle, and all bank states stay unchanged.
- R6: READ or WRITE with address bit 10 high returns the target bank to idle.
- R7: MODE SET with `ba`=0 pulses `mr_base_o`, and with `ba`=1 pulses `mr_ext_o`. The opcode `addr` appears on `mr_op_o`.
- R8: `cke` sampled low while running enters `pwr_mode_o`=1 (precharge power-down) if all banks are idle, or 2 (active power-down) if any is open. While powered down, commands are ignored and `cmd_o` reads 1. The cycle that samples `cke` high returns to 0 and is also ignored.
- R9: REFRESH sampled with `cke` low while running and all banks idle enters `pwr_mode_o`=3 (self refresh), and `cmd_o` reads 6.
- R10: `cke` sampled low during a READ/WRITE burst (BURST_LEN/2 cycles after the command), or together with a READ/WRITE, sets `cke_err_o`.
- R11: In each of the BURST_LEN/2 cycles after a WRITE, `wr_keep_o` bits 7:0 are set unless `dm[0]` is high, and bits 15:8 are set unless `dm[1]` is high. Outside a write burst `wr_keep_o` is 0.
- R12: Synchronous `rst` clears all banks, `pwr_mode_o`, flags and `wr_keep_o`, and sets `cmd_o` to 0.
- R13: BURST STOP ends the current burst, so a later low `cke` raises no burst error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column/auto-close or mode opcode |
| dm | input | 2 | Byte mask, bit 0 lower byte, bit 1 upper byte |
| cmd_o | output | 4 | Decoded command code |
| bank_o | output | 2 | Bank of the reported command |
| row_o | output | 13 | Row opened or accessed |
| col_o | output | 12 | Column of READ/WRITE |
| ap_o | output | 1 | Address bit 10 for READ/WRITE/PRECHARGE |
| mr_base_o | output | 1 | Base mode register written |
| mr_ext_o | output | 1 | Extended mode register written |
| mr_op_o | output | 13 | Mode opcode |
| illegal_o | output | 1 | Command illegal for bank state |
| cke_err_o | output | 1 | Clock enable dropped during burst |
| pwr_mode_o | output | 2 | 0 run, 1 precharge PD, 2 active PD, 3 self refresh |
| bank_active_o | output | 4 | Open flag per bank |
| wr_keep_o | output | 16 | Per-bit write keep pattern |

## Verification
A table walks all eight strobe codes plus deselect through a bank sequence. The sequence opens two banks, retries an open bank, reads an idle one, and issues a refresh with rows open, so legal and illegal versions of the same code give different flags and bank states. Single-bank and all-bank precharge are run while several banks are open, which tells bit 10 handling apart from plain bank selection. Directed runs drop clock enable with idle banks, with open banks, together with refresh, and mid-burst after a burst stop. Each of these must end in a different power mode or error result. Alternating mask bits inside and outside a write burst show lane mapping and window edges.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    localparam int AP_BIT = 10;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_REF   = 4'd6,
        CMD_MRS   = 4'd7,
        CMD_BST   = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'd0,
        PWR_PPD  = 2'd1,
        PWR_APD  = 2'd2,
        PWR_SREF = 2'd3
    } pwr_e;

    function automatic cmd_e pin_decode(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        if (cs_n) return CMD_DESEL;
        case ({ras_n, cas_n, we_n})
            3'b111:  return CMD_NOP;
            3'b011:  return CMD_ACT;
            3'b101:  return CMD_RD;
            3'b100:  return CMD_WR;
            3'b010:  return CMD_PRE;
            3'b001:  return CMD_REF;
            3'b000:  return CMD_MRS;
            default: return CMD_BST;
        endcase
    endfunction

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  pwr_e pwr,
    output cmd_e pin_cmd,
    output cmd_e exec_cmd,
    output logic pd_enter
);
    always_comb begin
        pin_cmd  = pin_decode(cs_n, ras_n, cas_n, we_n);
        exec_cmd = (pwr == PWR_RUN && cke) ? pin_cmd : CMD_NOP;
        pd_enter = (pwr == PWR_RUN) && !cke;
    end
endmodule

// File: rtl/ddr_bank_table.sv
module ddr_bank_table
    import ddr_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  cmd_e                 cmd,
    input  logic [BA_W-1:0]      ba,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_BANKS-1:0] active,
    output logic                 illegal,
    output logic [ADDR_W-1:0]    sel_row
);
    logic [ADDR_W-1:0] rows [NUM_BANKS];

    always_comb begin
        case (cmd)
            CMD_ACT:        illegal = active[ba];
            CMD_RD, CMD_WR: illegal = !active[ba];
            CMD_REF:        illegal = |active;
            default:        illegal = 1'b0;
        endcase
        sel_row = rows[ba];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic              open_q;
        logic [ADDR_W-1:0] row_q;
        logic              me;

        assign me      = (ba == BA_W'(b));
        assign active[b] = open_q;
        assign rows[b]   = row_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (!illegal) begin
                if (cmd == CMD_ACT && me) begin
                    open_q <= 1'b1;
                    row_q  <= addr;
                end else if (cmd == CMD_PRE && (addr[AP_BIT] || me)) begin
                    open_q <= 1'b0;
                end else if (is_access(cmd) && me && addr[AP_BIT]) begin
                    open_q <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/ddr_power_ctl.sv
module ddr_power_ctl
    import ddr_cmd_pkg::*;
#(
    parameter int BURST_CYC = 2,
    localparam int CNT_W    = $clog2(BURST_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  cmd_e pin_cmd,
    input  cmd_e exec_cmd,
    input  logic illegal,
    input  logic pd_enter,
    input  logic any_open,
    output pwr_e pwr,
    output logic sr_enter,
    output logic cke_err,
    output logic wr_window
);
    logic [CNT_W-1:0] cnt_q;
    logic             wr_q;

    always_comb begin
        sr_enter  = pd_enter && pin_cmd == CMD_REF && !any_open;
        cke_err   = !cke && ((cnt_q != '0) ||
                             (pwr == PWR_RUN && is_access(pin_cmd)));
        wr_window = wr_q && (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr   <= PWR_RUN;
            cnt_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            if (pwr != PWR_RUN) begin
                if (cke) pwr <= PWR_RUN;
            end else if (!cke) begin
                pwr <= sr_enter ? PWR_SREF : (any_open ? PWR_APD : PWR_PPD);
            end

            if (!cke || exec_cmd == CMD_BST) begin
                cnt_q <= '0;
            end else if (is_access(exec_cmd) && !illegal) begin
                cnt_q <= CNT_W'(BURST_CYC);
                wr_q  <= (exec_cmd == CMD_WR);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/ddr_wmask.sv
module ddr_wmask #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              window,
    input  logic [LANES-1:0]  dm,
    output logic [DATA_W-1:0] keep
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic lane_q;
        assign keep[l*8 +: 8] = {8{lane_q}};
        always_ff @(posedge clk) begin
            if (rst) lane_q <= 1'b0;
            else     lane_q <= window && !dm[l];
        end
    end
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cke,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W/8-1:0]          dm,
    output logic [3:0]                   cmd_o,
    output logic [$clog2(NUM_BANKS)-1:0] bank_o,
    output logic [ADDR_W-1:0]            row_o,
    output logic [ADDR_W-2:0]            col_o,
    output logic                         ap_o,
    output logic                         mr_base_o,
    output logic                         mr_ext_o,
    output logic [ADDR_W-1:0]            mr_op_o,
    output logic                         illegal_o,
    output logic                         cke_err_o,
    output logic [1:0]                   pwr_mode_o,
    output logic [NUM_BANKS-1:0]         bank_active_o,
    output logic [DATA_W-1:0]            wr_keep_o
);
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int BURST_CYC = BURST_LEN / 2;

    cmd_e              pin_cmd, exec_cmd;
    pwr_e              pwr;
    logic              pd_enter, illegal, sr_enter, cke_err, wr_window;
    logic [ADDR_W-1:0] sel_row;
    logic [ADDR_W-2:0] col;

    assign col = {addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:0]};

    ddr_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke),
        .pwr(pwr), .pin_cmd(pin_cmd), .exec_cmd(exec_cmd), .pd_enter(pd_enter)
    );

    ddr_bank_table #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_banks (
        .clk(clk), .rst(rst), .cmd(exec_cmd), .ba(ba), .addr(addr),
        .active(bank_active_o), .illegal(illegal), .sel_row(sel_row)
    );

    ddr_power_ctl #(.BURST_CYC(BURST_CYC)) u_pwr (
        .clk(clk), .rst(rst), .cke(cke), .pin_cmd(pin_cmd), .exec_cmd(exec_cmd),
        .illegal(illegal), .pd_enter(pd_enter), .any_open(|bank_active_o),
        .pwr(pwr), .sr_enter(sr_enter), .cke_err(cke_err), .wr_window(wr_window)
    );

    ddr_wmask #(.DATA_W(DATA_W)) u_mask (
        .clk(clk), .rst(rst), .window(wr_window), .dm(dm), .keep(wr_keep_o)
    );

    assign pwr_mode_o = pwr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o     <= CMD_DESEL;
            bank_o    <= '0;
            row_o     <= '0;
            col_o     <= '0;
            ap_o      <= 1'b0;
            mr_base_o <= 1'b0;
            mr_ext_o  <= 1'b0;
            mr_op_o   <= '0;
            illegal_o <= 1'b0;
            cke_err_o <= 1'b0;
        end else begin
            cmd_o     <= sr_enter ? CMD_REF : exec_cmd;
            bank_o    <= (exec_cmd == CMD_NOP || exec_cmd == CMD_DESEL) ? '0 : ba;
            row_o     <= (exec_cmd == CMD_ACT) ? addr :
                         (is_access(exec_cmd) ? sel_row : '0);
            col_o     <= is_access(exec_cmd) ? col : '0;
            ap_o      <= (is_access(exec_cmd) || exec_cmd == CMD_PRE) && addr[AP_BIT];
            mr_base_o <= (exec_cmd == CMD_MRS) && (ba == BA_W'(0));
            mr_ext_o  <= (exec_cmd == CMD_MRS) && (ba == BA_W'(1));
            mr_op_o   <= (exec_cmd == CMD_MRS) ? addr : '0;
            illegal_o <= illegal;
            cke_err_o <= cke_err;
        end
    end
endmodule

// File: rtl/ddr_cmd_tracker_chk.sv
module ddr_cmd_tracker_chk #(
    parameter int NUM_BANKS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [3:0]           cmd_o,
    input logic                 illegal_o,
    input logic                 cke_err_o,
    input logic                 mr_base_o,
    input logic                 mr_ext_o,
    input logic [1:0]           pwr_mode_o,
    input logic [NUM_BANKS-1:0] bank_active_o
);
    AST_DESEL_KEEPS_BANKS: assert property (@(posedge clk) disable iff (rst)
        cmd_o == 4'd0 |-> bank_active_o == $past(bank_active_o)); // R1
    AST_ILLEGAL_KEEPS_BANKS: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> bank_active_o == $past(bank_active_o)); // R5
    AST_MODE_PULSE_NEEDS_MRS: assert property (@(posedge clk) disable iff (rst)
        (mr_base_o || mr_ext_o) |-> cmd_o == 4'd7); // R7
    AST_MODE_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mr_base_o, mr_ext_o})); // R7
    AST_PPD_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
        pwr_mode_o == 2'd1 |-> bank_active_o == '0); // R8
    AST_APD_HAS_OPEN: assert property (@(posedge clk) disable iff (rst)
        pwr_mode_o == 2'd2 |-> bank_active_o != '0); // R8
    AST_SREF_ALL_IDLE: assert property (@(posedge clk) disable iff (rst)
        pwr_mode_o == 2'd3 |-> bank_active_o == '0); // R9
    AST_CKE_ERR_POWERS_DOWN: assert property (@(posedge clk) disable iff (rst)
        cke_err_o |-> pwr_mode_o != 2'd0); // R10
endmodule

bind ddr_cmd_tracker ddr_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk(clk), .rst(rst), .cmd_o(cmd_o), .illegal_o(illegal_o),
    .cke_err_o(cke_err_o), .mr_base_o(mr_base_o), .mr_ext_o(mr_ext_o),
    .pwr_mode_o(pwr_mode_o), .bank_active_o(bank_active_o)
);

// File: tb/ddr_cmd_tracker_test.sv
module ddr_cmd_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [1:0]  dm = '0;
    logic [3:0]  cmd_o;
    logic [1:0]  bank_o;
    logic [12:0] row_o;
    logic [11:0] col_o;
    logic        ap_o, mr_base_o, mr_ext_o, illegal_o, cke_err_o;
    logic [12:0] mr_op_o;
    logic [1:0]  pwr_mode_o;
    logic [3:0]  bank_active_o;
    logic [15:0] wr_keep_o;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr_cmd_tracker uut (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dm(dm),
        .cmd_o(cmd_o), .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
        .ap_o(ap_o), .mr_base_o(mr_base_o), .mr_ext_o(mr_ext_o),
        .mr_op_o(mr_op_o), .illegal_o(illegal_o), .cke_err_o(cke_err_o),
        .pwr_mode_o(pwr_mode_o), .bank_active_o(bank_active_o),
        .wr_keep_o(wr_keep_o)
    );

    // {cs_n, ras/cas/we, cke, ba, addr, dm, exp_cmd, exp_illegal, exp_active, exp_pwr}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0,3'b111,1'b1,2'd0,13'h0000,2'b00, 4'd1,1'b0,4'b0000,2'd0},
        {1'b1,3'b011,1'b1,2'd0,13'h0000,2'b00, 4'd0,1'b0,4'b0000,2'd0},
        {1'b0,3'b011,1'b1,2'd0,13'h0123,2'b00, 4'd2,1'b0,4'b0001,2'd0},
        {1'b0,3'b011,1'b1,2'd2,13'h1ABC,2'b00, 4'd2,1'b0,4'b0101,2'd0},
        {1'b0,3'b011,1'b1,2'd0,13'h0001,2'b00, 4'd2,1'b1,4'b0101,2'd0},
        {1'b0,3'b101,1'b1,2'd1,13'h0000,2'b00, 4'd3,1'b1,4'b0101,2'd0},
        {1'b0,3'b101,1'b1,2'd0,13'h0005,2'b00, 4'd3,1'b0,4'b0101,2'd0},
        {1'b0,3'b111,1'b1,2'd0,13'h0000,2'b00, 4'd1,1'b0,4'b0101,2'd0},
        {1'b0,3'b111,1'b1,2'd0,13'h0000,2'b00, 4'd1,1'b0,4'b0101,2'd0},
        {1'b0,3'b100,1'b1,2'd2,13'h0410,2'b00, 4'd4,1'b0,4'b0001,2'd0},
        {1'b0,3'b011,1'b1,2'd3,13'h0777,2'b00, 4'd2,1'b0,4'b1001,2'd0},
        {1'b0,3'b111,1'b1,2'd0,13'h0000,2'b00, 4'd1,1'b0,4'b1001,2'd0},
        {1'b0,3'b010,1'b1,2'd0,13'h0000,2'b00, 4'd5,1'b0,4'b1000,2'd0},
        {1'b0,3'b011,1'b1,2'd1,13'h0002,2'b00, 4'd2,1'b0,4'b1010,2'd0},
        {1'b0,3'b001,1'b1,2'd0,13'h0000,2'b00, 4'd6,1'b1,4'b1010,2'd0},
        {1'b0,3'b010,1'b1,2'd0,13'h0400,2'b00, 4'd5,1'b0,4'b0000,2'd0},
        {1'b0,3'b001,1'b1,2'd0,13'h0000,2'b00, 4'd6,1'b0,4'b0000,2'd0},
        {1'b0,3'b000,1'b1,2'd0,13'h0022,2'b00, 4'd7,1'b0,4'b0000,2'd0},
        {1'b0,3'b110,1'b1,2'd0,13'h0000,2'b00, 4'd8,1'b0,4'b0000,2'd0},
        {1'b1,3'b101,1'b1,2'd0,13'h0000,2'b00, 4'd0,1'b0,4'b0000,2'd0},
        {1'b0,3'b111,1'b1,2'd0,13'h0000,2'b00, 4'd1,1'b0,4'b0000,2'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge (one rising edge in between)
    task automatic step(input logic c, input logic [2:0] rcw, input logic k,
                        input logic [1:0] b, input logic [12:0] a, input logic [1:0] m);
        cs_n = c; {ras_n, cas_n, we_n} = rcw; cke = k; ba = b; addr = a; dm = m;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset cmd", 32'(cmd_o), 32'd0);
        check("R12 reset banks", 32'(bank_active_o), 32'd0);
        check("R12 reset pwr", 32'(pwr_mode_o), 32'd0);
        check("R12 reset keep", 32'(wr_keep_o), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [32:0] v;
            v = VEC[i];
            step(v[32], v[31:29], v[28], v[27:26], v[25:13], v[12:11]);
            check($sformatf("R2 vec%0d cmd", i), 32'(cmd_o), 32'(v[10:7]));
            check($sformatf("R5 vec%0d illegal", i), 32'(illegal_o), 32'(v[6]));
            check($sformatf("R4 R6 vec%0d banks", i), 32'(bank_active_o), 32'(v[5:2]));
            check($sformatf("R8 vec%0d pwr", i), 32'(pwr_mode_o), 32'(v[1:0]));
        end

        // R1: deselect with precharge-all strobes changes nothing
        step(1'b0, 3'b011, 1'b1, 2'd0, 13'h0123, 2'b00);
        step(1'b1, 3'b010, 1'b1, 2'd0, 13'h0400, 2'b00);
        check("R1 desel cmd", 32'(cmd_o), 32'd0);
        check("R1 desel banks", 32'(bank_active_o), 32'b0001);

        // R3: row and column reporting
        step(1'b0, 3'b011, 1'b1, 2'd1, 13'h0AAA, 2'b00);
        check("R3 act row", 32'(row_o), 32'h0AAA);
        check("R3 act bank", 32'(bank_o), 32'd1);
        step(1'b0, 3'b101, 1'b1, 2'd1, 13'h1803, 2'b00);
        check("R3 rd row", 32'(row_o), 32'h0AAA);
        check("R3 rd col", 32'(col_o), 32'hC03);
        check("R3 rd ap", 32'(ap_o), 32'd0);
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0, 2'b00);
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0, 2'b00);

        // R11: write mask window
        step(1'b0, 3'b100, 1'b1, 2'd1, 13'h0000, 2'b00);
        check("R11 keep at write cmd", 32'(wr_keep_o), 32'h0000);
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0, 2'b01);
        check("R11 beat lower masked", 32'(wr_keep_o), 32'hFF00);
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0, 2'b10);
        check("R11 beat upper masked", 32'(wr_keep_o), 32'h00FF);
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0, 2'b01);
        check("R11 after window", 32'(wr_keep_o), 32'h0000);

        // R7: mode register selection
        step(1'b0, 3'b000, 1'b1, 2'd1, 13'h0055, 2'b00);
        check("R7 ext pulse", 32'(mr_ext_o), 32'd1);
        check("R7 base idle", 32'(mr_base_o), 32'd0);
        check("R7 opcode", 32'(mr_op_o), 32'h0055);
        step(1'b0, 3'b000, 1'b1, 2'd0, 13'h0031, 2'b00);
        check("R7 base pulse", 32'(mr_base_o), 32'd1);
        check("R7 ext idle", 32'(mr_ext_o), 32'd0);

        // R13: burst stop clears burst; R8 active power-down
        step(1'b0, 3'b101, 1'b1, 2'd1, 13'h0000, 2'b00);
        step(1'b0, 3'b110, 1'b1, 2'd0, 13'h0000, 2'b00);
        step(1'b0, 3'b111, 1'b0, 2'd0, 13'h0000, 2'b00);
        check("R13 no err after stop", 32'(cke_err_o), 32'd0);
        check("R8 active pd", 32'(pwr_mode_o), 32'd2);
        step(1'b0, 3'b011, 1'b0, 2'd2, 13'h0001, 2'b00);
        check("R8 pd ignores act", 32'(bank_active_o), 32'b0011);
        check("R8 pd cmd nop", 32'(cmd_o), 32'd1);
        step(1'b0, 3'b011, 1'b1, 2'd2, 13'h0001, 2'b00);
        check("R8 exit pwr", 32'(pwr_mode_o), 32'd0);
        check("R8 exit ignored", 32'(bank_active_o), 32'b0011);

        // R10: cke dropped mid burst
        step(1'b0, 3'b101, 1'b1, 2'd0, 13'h0000, 2'b00);
        step(1'b0, 3'b111, 1'b0, 2'd0, 13'h0000, 2'b00);
        check("R10 cke err", 32'(cke_err_o), 32'd1);
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0000, 2'b00);
        check("R10 err clears", 32'(cke_err_o), 32'd0);

        // R8 precharge power-down
        step(1'b0, 3'b010, 1'b1, 2'd0, 13'h0400, 2'b00);
        step(1'b0, 3'b111, 1'b0, 2'd0, 13'h0000, 2'b00);
        check("R8 precharge pd", 32'(pwr_mode_o), 32'd1);
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0000, 2'b00);

        // R9 self refresh
        step(1'b0, 3'b001, 1'b0, 2'd0, 13'h0000, 2'b00);
        check("R9 sref mode", 32'(pwr_mode_o), 32'd3);
        check("R9 sref cmd", 32'(cmd_o), 32'd6);
        step(1'b0, 3'b111, 1'b0, 2'd0, 13'h0000, 2'b00);
        check("R9 sref held", 32'(pwr_mode_o), 32'd3);
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0000, 2'b00);
        check("R9 sref exit", 32'(pwr_mode_o), 32'd0);

        // R6 auto-close on read
        step(1'b0, 3'b011, 1'b1, 2'd3, 13'h0044, 2'b00);
        step(1'b0, 3'b101, 1'b1, 2'd3, 13'h0400, 2'b00);
        check("R6 bank closed", 32'(bank_active_o), 32'b0000);
        check("R6 ap flag", 32'(ap_o), 32'd1);

        // R12 mid-run reset
        step(1'b0, 3'b011, 1'b1, 2'd2, 13'h0009, 2'b00);
        rst = 1'b1;
        step(1'b0, 3'b111, 1'b1, 2'd0, 13'h0000, 2'b00);
        check("R12 mid reset banks", 32'(bank_active_o), 32'd0);
        check("R12 mid reset cmd", 32'(cmd_o), 32'd0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule